// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Per-Entry Page Masks

This block is a small fully associative translation buffer for a memory management unit. Each slot holds a virtual page-pair number, a page mask, an address-space tag, a global flag, and two physical halves (even and odd). Each half has its own frame number, cache attribute, dirty bit and valid bit. A slot's mask widens its page: where the mask has ones, those page-number bits are left out of the compare. The virtual-address bit just above the widened offset then picks the even or the odd half.

Lookup and probe are combinational. Writes by index take the same packed words that software places in the translation registers. A flush input empties the table. A round-robin next-slot pointer gives the refill path a default write index. Any address in the uncached window is flagged, whatever the lookup finds.

Top module: `pair_tlb`

## Requirements
- R1: A slot matches only when `lk_va[31:11]` equals the stored page-pair number in every bit where the slot's mask is 0. Bits where the mask is 1 are ignored.
- R2: A match also needs the slot's global flag set or `lk_asid` equal to the stored tag. The global flag is the AND of bit 0 of the two low words written.
- R3: A slot whose even and odd valid bits are both clear never matches, in lookup or in probe.
- R4: On a hit, with k ones in the (contiguous, low-aligned) mask, `lk_va[10+k]` selects the odd half when 1 and the even half when 0. `lk_pfn`, `lk_cattr` and `lk_dirty` come from that half, and `lk_valid` is that half's valid bit. On a miss all four are 0.
- R5: When several slots match, the lowest index drives `lk_idx` and the data, and `lk_multi` is 1. `lk_multi` is 0 when at most one slot matches.
- R6: The probe port applies the R1 to R3 rules to `pr_vpn`/`pr_asid`. It returns `pr_found`=1 with the lowest matching index, or `pr_found`=0 with `pr_index`=0.
- R7: A write with `wr_en`=1 and `wr_index` below ENTRIES replaces the whole slot from the packed words. The words are laid out as follows. `wr_mask[31:11]` is the mask. `wr_hi[31:11]` is the page-pair number and `wr_hi[7:0]` the tag. In each low word, `[25:6]` is the frame, `[5:3]` the cache attribute, `[2]` dirty, `[1]` valid and `[0]` global. `wr_lo0` is the even half and `wr_lo1` the odd half.
- R8: A write with `wr_index` >= ENTRIES changes no slot. `wr_warn` is 1 in the cycle after it and 0 after any other cycle.
- R9: `flush` clears every slot and sets `nxt_ptr` to 0 at the next edge. It takes priority over a write and an advance in the same cycle.
- R10: `lk_uncached` is 1 exactly when `lk_va[31]` and `lk_va[29]` are both 1, independent of the lookup result.
- R11: `nxt_ptr` shows the current next slot. With `nxt_adv`=1 it steps by one at the edge and wraps from ENTRIES-1 to 0. Otherwise it holds.
- R12: After synchronous reset every slot is empty, `nxt_ptr` is 0 and `wr_warn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | Some slot matches |
| lk_idx | output | IDX_W | Index of the winning slot |
| lk_multi | output | 1 | More than one slot matches |
| lk_valid | output | 1 | Selected half is valid |
| lk_pfn | output | 20 | Selected half's frame number |
| lk_cattr | output | 3 | Selected half's cache attribute |
| lk_dirty | output | 1 | Selected half's dirty bit |
| lk_uncached | output | 1 | Address lies in the uncached, strictly ordered window |
| pr_vpn | input | 21 | Probe page-pair number |
| pr_asid | input | 8 | Probe tag |
| pr_found | output | 1 | Probe matched |
| pr_index | output | IDX_W | Probe match index |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | IDX_W+1 | Write slot index |
| wr_mask | input | 32 | Packed mask word |
| wr_hi | input | 32 | Packed page-number/tag word |
| wr_lo0 | input | 32 | Packed even-half word |
| wr_lo1 | input | 32 | Packed odd-half word |
| flush | input | 1 | Clear all slots and the pointer |
| nxt_adv | input | 1 | Advance the next-slot pointer |
| nxt_ptr | output | IDX_W | Next-slot pointer |
| wr_warn | output | 1 | Previous cycle's write index was out of range |

## Verification
The assertions assume that the masks written are runs of ones starting at bit 0. The probe-agreement property also assumes that the probe and lookup ports carry the same page number and tag whenever they are compared. The stimulus writes only masks from the set 0, 1, 3, 7 and 15. Most cycles the probe inputs copy the lookup address, so the agreement check fires often. Page numbers and tags are drawn from small ranges, which makes overlapping slots, and so multiple matches, common.

// File: rtl/pair_tlb_pkg.sv
// Package: shared slot types, field widths and the packed-word decoder.
// Assumes the 32-bit register word layout given in the brief.
package pair_tlb_pkg;
    localparam int VPN_W   = 21;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 20;
    localparam int CATTR_W = 3;
    localparam int PG_LSB  = 11;
    localparam logic [31:0] UNCACHED_PAT = 32'hA000_0000;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } half_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        half_t             even;
        half_t             odd;
    } entry_t;

    // Decode one low word into a half.
    function automatic half_t unpack_half(input logic [31:0] w);
        half_t h;
        h.pfn   = w[6 +: PFN_W];
        h.cattr = w[5:3];
        h.dirty = w[2];
        h.valid = w[1];
        return h;
    endfunction

    // Decode the four register words into a slot.
    function automatic entry_t unpack_entry(input logic [31:0] mw, input logic [31:0] hw,
                                            input logic [31:0] l0, input logic [31:0] l1);
        entry_t e;
        e.mask = mw[PG_LSB +: VPN_W];
        e.vpn  = hw[PG_LSB +: VPN_W];
        e.asid = hw[ASID_W-1:0];
        e.glob = l0[0] & l1[0];
        e.even = unpack_half(l0);
        e.odd  = unpack_half(l1);
        return e;
    endfunction
endpackage

// File: rtl/pair_tlb_match.sv
// Per-slot comparator array: one match bit per slot for a given
// page-pair number and tag. Assumes nothing about mask shape.
module pair_tlb_match
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  entry_t              ents [ENTRIES],
    input  logic [VPN_W-1:0]    vpn,
    input  logic [ASID_W-1:0]   asid,
    output logic [ENTRIES-1:0]  hit_vec
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic live, tag_ok, page_ok;
        // Compare one slot against the request.
        always_comb begin
            live    = ents[i].even.valid | ents[i].odd.valid;
            tag_ok  = ents[i].glob | (ents[i].asid == asid);
            page_ok = ((vpn ^ ents[i].vpn) & ~ents[i].mask) == '0;
            hit_vec[i] = live & tag_ok & page_ok;
        end
    end
endmodule

// File: rtl/pair_tlb_prio.sv
// Lowest-index priority picker with a multiple-request flag.
// Assumes N >= 2.
module pair_tlb_prio #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic             multi
);
    // Scan from index 0 upward, keep the first request seen.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        multi = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                if (found) begin
                    multi = 1'b1;
                end else begin
                    found = 1'b1;
                    idx   = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/pair_tlb.sv
// Fully associative paired-page translation buffer. Holds ENTRIES slots,
// serves a combinational lookup and probe, takes indexed writes from packed
// register words, flushes on request and keeps a round-robin refill pointer.
// Assumes masks written are contiguous runs of ones from bit 0.
module pair_tlb
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        lk_va,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic               lk_multi,
    output logic               lk_valid,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [CATTR_W-1:0] lk_cattr,
    output logic               lk_dirty,
    output logic               lk_uncached,
    input  logic [VPN_W-1:0]   pr_vpn,
    input  logic [ASID_W-1:0]  pr_asid,
    output logic               pr_found,
    output logic [IDX_W-1:0]   pr_index,
    input  logic               wr_en,
    input  logic [IDX_W:0]     wr_index,
    input  logic [31:0]        wr_mask,
    input  logic [31:0]        wr_hi,
    input  logic [31:0]        wr_lo0,
    input  logic [31:0]        wr_lo1,
    input  logic               flush,
    input  logic               nxt_adv,
    output logic [IDX_W-1:0]   nxt_ptr,
    output logic               wr_warn
);
    localparam logic [IDX_W:0]   LIMIT    = (IDX_W+1)'(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    entry_t              ents [ENTRIES];
    logic [ENTRIES-1:0]  lk_vec, pr_vec;
    logic                lk_found, lk_many;
    logic [IDX_W-1:0]    lk_win;
    logic                wr_ok;
    logic                unused_bits;

    assign wr_ok       = wr_en && (wr_index < LIMIT);
    assign unused_bits = ^{lk_va[9:0], wr_mask[10:0], wr_hi[10:8], wr_lo0[31:26], wr_lo1[31:26]};

    // Slot storage: reset and flush empty it, an in-range write replaces one slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (wr_ok) begin
            ents[wr_index[IDX_W-1:0]] <= unpack_entry(wr_mask, wr_hi, wr_lo0, wr_lo1);
        end
    end

    // Refill pointer: cleared by reset or flush, steps with wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  nxt_ptr <= '0;
        else if (nxt_adv)     nxt_ptr <= (nxt_ptr == LAST_IDX) ? '0 : nxt_ptr + 1'b1;
    end

    // Out-of-range write flag, one cycle after the offending write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_warn <= 1'b0;
        else        wr_warn <= wr_en && !(wr_index < LIMIT);
    end

    pair_tlb_match #(.ENTRIES(ENTRIES)) lk_cmp_i (
        .ents(ents), .vpn(lk_va[31:PG_LSB]), .asid(lk_asid), .hit_vec(lk_vec));
    pair_tlb_prio #(.N(ENTRIES)) lk_pick_i (
        .req(lk_vec), .found(lk_found), .idx(lk_win), .multi(lk_many));

    pair_tlb_match #(.ENTRIES(ENTRIES)) pr_cmp_i (
        .ents(ents), .vpn(pr_vpn), .asid(pr_asid), .hit_vec(pr_vec));
    pair_tlb_prio #(.N(ENTRIES)) pr_pick_i (
        .req(pr_vec), .found(pr_found), .idx(pr_index), .multi());

    entry_t          sel;
    logic [VPN_W:0]  pick_bit;
    logic            odd_half;
    half_t           half;

    // Pick the half from the address bit just above the widened offset.
    always_comb begin
        sel      = ents[lk_win];
        pick_bit = {sel.mask, 1'b1} & ~{1'b0, sel.mask};
        odd_half = |(lk_va[31:PG_LSB-1] & pick_bit);
        half     = odd_half ? sel.odd : sel.even;
    end

    // Drive the translation outputs, zeroed on a miss.
    always_comb begin
        lk_hit      = lk_found;
        lk_idx      = lk_win;
        lk_multi    = lk_many;
        lk_valid    = lk_found & half.valid;
        lk_pfn      = lk_found ? half.pfn   : '0;
        lk_cattr    = lk_found ? half.cattr : '0;
        lk_dirty    = lk_found & half.dirty;
        lk_uncached = (lk_va & UNCACHED_PAT) == UNCACHED_PAT;
    end
endmodule

// File: rtl/pair_tlb_chk.sv
// Checker for pair_tlb: temporal properties on ports, bound to every instance.
// Assumes rst_n is low from time zero until the first edges have passed.
module pair_tlb_chk #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      lk_va,
    input logic [7:0]       lk_asid,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx,
    input logic             lk_multi,
    input logic             lk_valid,
    input logic             lk_uncached,
    input logic [20:0]      pr_vpn,
    input logic [7:0]       pr_asid,
    input logic             pr_found,
    input logic [IDX_W-1:0] pr_index,
    input logic             wr_en,
    input logic [IDX_W:0]   wr_index,
    input logic             flush,
    input logic             nxt_adv,
    input logic [IDX_W-1:0] nxt_ptr,
    input logic             wr_warn
);
    localparam logic [IDX_W:0]   LIMIT    = (IDX_W+1)'(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    // R5
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);
    // R4
    valid_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> lk_hit);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_hit && !pr_found && nxt_ptr == '0));
    // R11
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_adv && !flush) |=>
            nxt_ptr == (($past(nxt_ptr) == LAST_IDX) ? '0 : $past(nxt_ptr) + 1'b1));
    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nxt_adv && !flush) |=> $stable(nxt_ptr));
    // R8
    warn_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_index < LIMIT)) |=> wr_warn);
    // R8
    warn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !(wr_index < LIMIT)) |=> !wr_warn);
    // R6
    probe_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_vpn == lk_va[31:11] && pr_asid == lk_asid) |->
            (pr_found == lk_hit && (!pr_found || pr_index == lk_idx)));
    // R10
    uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_va[31] && lk_va[29]) |-> lk_uncached);
endmodule

bind pair_tlb pair_tlb_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_asid(lk_asid), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_multi(lk_multi), .lk_valid(lk_valid), .lk_uncached(lk_uncached),
    .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_found(pr_found), .pr_index(pr_index),
    .wr_en(wr_en), .wr_index(wr_index), .flush(flush), .nxt_adv(nxt_adv),
    .nxt_ptr(nxt_ptr), .wr_warn(wr_warn));

// File: tb/pair_tlb_tb_top.sv
module pair_tlb_tb_top;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic lk_hit, lk_multi, lk_valid, lk_dirty, lk_uncached, pr_found, wr_warn;
    logic [IW-1:0] lk_idx, pr_index, nxt_ptr;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_cattr;
    logic [20:0] pr_vpn = '0;
    logic [7:0]  pr_asid = '0;
    logic wr_en = 1'b0, flush = 1'b0, nxt_adv = 1'b0;
    logic [IW:0] wr_index = '0;
    logic [31:0] wr_mask = '0, wr_hi = '0, wr_lo0 = '0, wr_lo1 = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [20:0] m_vpn [N], m_mask [N];
    logic [7:0]  m_asid [N];
    bit          m_g [N];
    logic [19:0] m_pfn [N][2];
    logic [2:0]  m_c [N][2];
    bit          m_d [N][2], m_v [N][2];
    int          m_ptr;
    bit          m_warn;

    always #10 clk = ~clk;

    pair_tlb #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_asid(lk_asid), .lk_hit(lk_hit),
        .lk_idx(lk_idx), .lk_multi(lk_multi), .lk_valid(lk_valid), .lk_pfn(lk_pfn),
        .lk_cattr(lk_cattr), .lk_dirty(lk_dirty), .lk_uncached(lk_uncached),
        .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_found(pr_found), .pr_index(pr_index),
        .wr_en(wr_en), .wr_index(wr_index), .wr_mask(wr_mask), .wr_hi(wr_hi),
        .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .flush(flush), .nxt_adv(nxt_adv),
        .nxt_ptr(nxt_ptr), .wr_warn(wr_warn));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0;
            for (int h = 0; h < 2; h++) begin
                m_pfn[i][h] = '0; m_c[i][h] = '0; m_d[i][h] = 0; m_v[i][h] = 0;
            end
        end
    endtask

    // Search the model: first match, more-than-one flag, half select.
    task automatic search(input logic [31:0] va, input logic [7:0] asid,
                          output bit hit, output int idx, output bit multi, output int half);
        hit = 0; idx = 0; multi = 0; half = 0;
        for (int i = 0; i < N; i++) begin
            if ((m_v[i][0] || m_v[i][1]) && (m_g[i] || m_asid[i] == asid) &&
                (((va[31:11] ^ m_vpn[i]) & ~m_mask[i]) == 21'd0)) begin
                if (hit) multi = 1;
                else begin hit = 1; idx = i; end
            end
        end
        if (hit) begin
            int k = $countones(m_mask[idx]);
            half = (10 + k <= 31) ? int'(va[10 + k]) : 0;
        end
    endtask

    task automatic compare();
        bit h, mu, ph, pm;
        int ix, hf, pix, phf;
        search(lk_va, lk_asid, h, ix, mu, hf);
        // R1 R2 R3 lookup match
        chk("R1 R2 R3 lk_hit", 32'(lk_hit), 32'(h));
        // R5 winner and multi
        chk("R5 lk_idx", 32'(lk_idx), h ? 32'(ix) : 32'd0);
        chk("R5 lk_multi", 32'(lk_multi), 32'(mu));
        // R4 half data
        chk("R4 lk_valid", 32'(lk_valid), h ? 32'(m_v[ix][hf]) : 32'd0);
        chk("R4 lk_pfn", 32'(lk_pfn), h ? 32'(m_pfn[ix][hf]) : 32'd0);
        chk("R4 lk_cattr", 32'(lk_cattr), h ? 32'(m_c[ix][hf]) : 32'd0);
        chk("R4 lk_dirty", 32'(lk_dirty), h ? 32'(m_d[ix][hf]) : 32'd0);
        // R10 uncached window
        chk("R10 lk_uncached", 32'(lk_uncached), 32'(lk_va[31] && lk_va[29]));
        // R6 probe
        search({pr_vpn, 11'd0}, pr_asid, ph, pix, pm, phf);
        chk("R6 pr_found", 32'(pr_found), 32'(ph));
        chk("R6 pr_index", 32'(pr_index), ph ? 32'(pix) : 32'd0);
        // R11 pointer, R8 warn
        chk("R11 nxt_ptr", 32'(nxt_ptr), 32'(m_ptr));
        chk("R8 wr_warn", 32'(wr_warn), 32'(m_warn));
    endtask

    task automatic update();
        if (!rst_n) begin
            model_clear(); m_ptr = 0; m_warn = 0;
        end else begin
            m_warn = wr_en && (int'(wr_index) >= N);
            if (flush) begin
                model_clear(); m_ptr = 0;
            end else begin
                if (wr_en && int'(wr_index) < N) begin
                    int i = int'(wr_index);
                    m_vpn[i] = wr_hi[31:11]; m_asid[i] = wr_hi[7:0];
                    m_mask[i] = wr_mask[31:11]; m_g[i] = wr_lo0[0] & wr_lo1[0];
                    m_pfn[i][0] = wr_lo0[25:6]; m_c[i][0] = wr_lo0[5:3];
                    m_d[i][0] = wr_lo0[2]; m_v[i][0] = wr_lo0[1];
                    m_pfn[i][1] = wr_lo1[25:6]; m_c[i][1] = wr_lo1[5:3];
                    m_d[i][1] = wr_lo1[2]; m_v[i][1] = wr_lo1[1];
                end
                if (nxt_adv) m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
        end
    endtask

    // One clock: compare before the edge, step the model at the edge.
    task automatic tick();
        #5;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic put(input int idx, input logic [20:0] vpn, input logic [20:0] mask,
                       input logic [7:0] asid, input logic [31:0] lo0, input logic [31:0] lo1);
        wr_en = 1; wr_index = (IW+1)'(idx);
        wr_mask = {mask, 11'd0}; wr_hi = {vpn, 3'd0, asid};
        wr_lo0 = lo0; wr_lo1 = lo1;
        tick();
        wr_en = 0;
    endtask

    function automatic logic [31:0] lo(input logic [19:0] pfn, input logic [2:0] c,
                                       input bit d, input bit v, input bit g);
        return {6'd0, pfn, c, d, v, g};
    endfunction

    task automatic look(input logic [20:0] vpn, input logic [10:0] low, input logic [7:0] asid);
        lk_va = {vpn, low}; lk_asid = asid; pr_vpn = vpn; pr_asid = asid;
        #2;
    endtask

    initial begin
        model_clear(); m_ptr = 0; m_warn = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1;
        // R12 reset state
        #2;
        chk("R12 nxt_ptr", 32'(nxt_ptr), 0);
        chk("R12 wr_warn", 32'(wr_warn), 0);
        chk("R12 lk_hit", 32'(lk_hit), 0);
        tick();

        // R7 write with packed words; R2 global is AND of bit 0
        put(0, 21'h100, 21'h0, 8'd5, lo(20'h111, 3'd2, 1, 1, 1), lo(20'h222, 3'd3, 0, 1, 0));
        look(21'h100, 11'h000, 8'd5);
        chk("R7 even pfn", 32'(lk_pfn), 32'h111);
        chk("R4 even cattr", 32'(lk_cattr), 2);
        tick();
        look(21'h100, 11'h400, 8'd5);
        chk("R4 odd pfn", 32'(lk_pfn), 32'h222);
        tick();
        look(21'h100, 11'h000, 8'd6);
        chk("R2 tag mismatch", 32'(lk_hit), 0);
        tick();

        // R1 masked compare, global slot, select bit moves up
        put(1, 21'h200, 21'h3, 8'd9, lo(20'h333, 3'd1, 0, 1, 1), lo(20'h444, 3'd4, 1, 1, 1));
        look(21'h201, 11'h000, 8'd1);
        chk("R1 masked hit", 32'(lk_hit), 1);
        chk("R4 select even", 32'(lk_pfn), 32'h333);
        tick();
        look(21'h203, 11'h7FF, 8'd77);
        chk("R4 select odd", 32'(lk_pfn), 32'h444);
        tick();
        look(21'h204, 11'h000, 8'd9);
        chk("R1 unmasked bit differs", 32'(lk_hit), 0);
        tick();

        // R4 hit on half with valid clear
        put(2, 21'h300, 21'h0, 8'd0, lo(20'h555, 3'd0, 0, 0, 1), lo(20'h666, 3'd0, 0, 1, 1));
        look(21'h300, 11'h000, 8'd3);
        chk("R4 hit invalid half", 32'({lk_hit, lk_valid}), 32'b10);
        tick();

        // R3 both valid clear never matches
        put(3, 21'h400, 21'h0, 8'd0, lo(20'h777, 3'd0, 0, 0, 1), lo(20'h777, 3'd0, 0, 0, 1));
        look(21'h400, 11'h000, 8'd0);
        chk("R3 no valid no hit", 32'({lk_hit, pr_found}), 0);
        tick();

        // R5 overlap, lowest index wins
        put(6, 21'h500, 21'h0, 8'd0, lo(20'h0AA, 3'd0, 0, 1, 1), lo(20'h0AA, 3'd0, 0, 1, 1));
        put(5, 21'h500, 21'h1, 8'd0, lo(20'h0BB, 3'd0, 0, 1, 1), lo(20'h0BB, 3'd0, 0, 1, 1));
        look(21'h500, 11'h000, 8'd2);
        chk("R5 lowest idx", 32'(lk_idx), 5);
        chk("R5 multi", 32'(lk_multi), 1);
        chk("R6 probe idx", 32'(pr_index), 5);
        tick();

        // R8 out-of-range write
        put(8, 21'h600, 21'h0, 8'd0, lo(20'h1, 3'd0, 0, 1, 1), lo(20'h1, 3'd0, 0, 1, 1));
        look(21'h600, 11'h000, 8'd0);
        chk("R8 warn", 32'(wr_warn), 1);
        chk("R8 no slot written", 32'(lk_hit), 0);
        tick();
        chk("R8 warn drops", 32'(wr_warn), 0);

        // R11 pointer wrap
        nxt_adv = 1;
        for (int i = 0; i < N + 2; i++) tick();
        nxt_adv = 0;
        #2 chk("R11 wrapped", 32'(nxt_ptr), 2);
        tick();

        // R10 uncached window
        lk_va = 32'hA000_0000; #2 chk("R10 window", 32'(lk_uncached), 1); tick();
        lk_va = 32'h2000_0000; #2 chk("R10 outside", 32'(lk_uncached), 0); tick();

        // R9 flush beats write and advance
        flush = 1; nxt_adv = 1;
        wr_en = 1; wr_index = '0; wr_hi = {21'h100, 11'd5}; wr_mask = '0;
        wr_lo0 = lo(20'h9, 3'd0, 0, 1, 1); wr_lo1 = wr_lo0;
        tick();
        flush = 0; nxt_adv = 0; wr_en = 0;
        look(21'h100, 11'h000, 8'd5);
        chk("R9 empty", 32'({lk_hit, pr_found}), 0);
        chk("R9 ptr zero", 32'(nxt_ptr), 0);
        tick();

        // mixed random traffic
        for (int c = 0; c < 3000; c++) begin
            int mk = $urandom_range(0, 4);
            logic [20:0] vp = 21'($urandom_range(0, 15));
            wr_en    = ($urandom_range(0, 3) == 0);
            wr_index = (IW+1)'($urandom_range(0, N + 1));
            wr_mask  = {21'((1 << mk) - 1), 11'd0};
            wr_hi    = {21'($urandom_range(0, 15)), 3'd0, 8'($urandom_range(0, 3))};
            wr_lo0   = $urandom; wr_lo1 = $urandom;
            flush    = ($urandom_range(0, 199) == 0);
            nxt_adv  = $urandom_range(0, 1) == 1;
            lk_va    = {vp, 11'($urandom)};
            if ($urandom_range(0, 15) == 0) lk_va = lk_va | 32'hA000_0000;
            lk_asid  = 8'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) begin
                pr_vpn = 21'($urandom_range(0, 15)); pr_asid = 8'($urandom_range(0, 3));
            end else begin
                pr_vpn = lk_va[31:11]; pr_asid = lk_asid;
            end
            tick();
        end
        wr_en = 0; flush = 0; nxt_adv = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule